// File: doc/BRIEF.md
# Gain Control Register Interface

This block is the processor-side write port of a programmable gain/attenuator. A host puts an 8-bit word, one address bit, an active-low select and an active-low write strobe on its pins. The block holds a 10-bit control word and turns it into the drive signals of the analog section: two one-hot tap selects (coarse and fine), a gain/attenuate flag, a powerdown flag, an analog enable and an output-drive enable. It also gives a signed readout of the programmed gain in tenths of a decibel.

All host pins are asynchronous to the block. They pass through two-flop synchronizers into one system clock domain. A write is taken on the low-to-high transition of the synchronized strobe, using the address, select and data sampled in the same clock. The gain word is 8 bits and the mode and powerdown bits are 2 more, so a full setting takes two writes. Powerdown blanks the analog enables but leaves the stored gain untouched, and the registers stay writable while powered down.

Top module: `gainctl_top`

## Requirements
- R1: A write takes effect on the rising edge of `bus_wr_n` only. Holding `bus_wr_n` low for any number of cycles changes no output.
- R2: If `bus_cs_n` is high when `bus_wr_n` rises, the write is ignored and every output keeps its value.
- R3: With `bus_addr`=0 a write loads the coarse code from data bits 7..4 and the fine code from bits 3..0. With `bus_addr`=1 it loads the mode from bit 0 and powerdown from bit 1. Each write leaves the other register unchanged.
- R4: `coarse_sel` has exactly one bit set, at the index equal to the coarse code. `fine_sel` has exactly one bit set, at the index equal to the fine code.
- R5: `gain_mode`=1 means gain and 0 means attenuate. `gain_tenths` equals +(15*coarse+fine) in gain mode and -(15*coarse+fine) in attenuate mode.
- R6: While the powerdown bit is 1, `pwr_down`=1 and `analog_en`=0, and `out_enable`=0 requests high impedance. When the bit is 0, `analog_en` and `out_enable` are both 1.
- R7: During powerdown, gain-word writes are still accepted, and the stored gain word is kept across entering and leaving powerdown.
- R8: After reset both codes are 0, so `coarse_sel`=`fine_sel`=1. The mode is attenuate, powerdown is 0 and `gain_tenths` is 0.
- R9: All outputs update together. Take the first clock edge that samples `bus_wr_n` high as edge 0: the outputs still show the old word after edge 2 and show the new word after edge 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_data | input | 8 | Host write data |
| bus_addr | input | 1 | Register select: 0 gain word, 1 mode/powerdown |
| bus_cs_n | input | 1 | Active-low chip select |
| bus_wr_n | input | 1 | Active-low write strobe; data taken on its rising edge |
| coarse_sel | output | 16 | One-hot coarse tap select (1.5 dB per step) |
| fine_sel | output | 16 | One-hot fine tap select (0.1 dB per step) |
| gain_mode | output | 1 | 1 = gain, 0 = attenuate |
| pwr_down | output | 1 | Stored powerdown bit |
| analog_en | output | 1 | Analog section enable |
| out_enable | output | 1 | 1 = drive output, 0 = request high impedance |
| gain_tenths | output | 10 | Signed programmed gain in 0.1 dB units |

## Verification
Some properties are checked by assertions on every clock:
- each internal write pulse lasts one clock;
- a register without a write pulse holds its value, including the gain word while powered down;
- both tap selects stay one-hot;
- a stored powerdown bit is followed by blanked enables.

Other behaviour needs the bench's scenarios: the bit mapping of each address, the signed readout values, ignored writes under a high select, the hold-low case, and the exact latency from the strobe edge to the outputs.

// File: rtl/gainctl_pkg.sv
package gainctl_pkg;
  localparam int DATA_W      = 8;
  localparam int CODE_W      = 4;
  localparam int TAPS        = 1 << CODE_W;
  localparam int COARSE_STEP = 15;   // one coarse step equals 15 fine steps
  localparam int GAIN_W      = 10;

  typedef struct packed {
    logic [CODE_W-1:0] coarse;
    logic [CODE_W-1:0] fine;
    logic              boost;  // 1 gain, 0 attenuate
    logic              pdn;
  } ctl_word_t;

  function automatic logic [TAPS-1:0] tap_onehot(input logic [CODE_W-1:0] code);
    logic [TAPS-1:0] v;
    v = '0;
    v[code] = 1'b1;
    return v;
  endfunction

  function automatic logic signed [GAIN_W-1:0] gain_readout(
      input logic [CODE_W-1:0] coarse, input logic [CODE_W-1:0] fine, input logic boost);
    logic signed [GAIN_W-1:0] mag;
    mag = GAIN_W'(COARSE_STEP * int'(coarse) + int'(fine));
    return boost ? mag : -mag;
  endfunction
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= RST_VAL;
      else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/write_detect.sv
module write_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_n_s,
  input  logic cs_n_s,
  input  logic addr_s,
  output logic lo_stb,
  output logic hi_stb
);
  logic wr_prev;
  logic wr_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_prev <= 1'b1;
    else        wr_prev <= wr_n_s;
  end

  assign wr_rise = wr_n_s & ~wr_prev;
  assign lo_stb  = wr_rise & ~cs_n_s & ~addr_s;
  assign hi_stb  = wr_rise & ~cs_n_s &  addr_s;

  AST_LO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    lo_stb |=> !lo_stb);                                       // R1
  AST_HI_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    hi_stb |=> !hi_stb);                                       // R1
endmodule

// File: rtl/ctl_regs.sv
module ctl_regs
  import gainctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_stb,
  input  logic              hi_stb,
  input  logic [DATA_W-1:0] data_s,
  output ctl_word_t         word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word.coarse <= '0;
      word.fine   <= '0;
    end else if (lo_stb) begin
      word.coarse <= data_s[2*CODE_W-1:CODE_W];
      word.fine   <= data_s[CODE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word.boost <= 1'b0;
      word.pdn   <= 1'b0;
    end else if (hi_stb) begin
      word.boost <= data_s[0];
      word.pdn   <= data_s[1];
    end
  end

  AST_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_stb |=> ($stable(word.coarse) && $stable(word.fine)));  // R3
  AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_stb |=> ($stable(word.boost) && $stable(word.pdn)));    // R3
  AST_PDN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (word.pdn && hi_stb) |=> ($stable(word.coarse) && $stable(word.fine))); // R7
endmodule

// File: rtl/out_stage.sv
module out_stage
  import gainctl_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  ctl_word_t                word,
  output logic [TAPS-1:0]          coarse_sel,
  output logic [TAPS-1:0]          fine_sel,
  output logic                     gain_mode,
  output logic                     pwr_down,
  output logic                     analog_en,
  output logic                     out_enable,
  output logic signed [GAIN_W-1:0] gain_tenths
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coarse_sel  <= tap_onehot('0);
      fine_sel    <= tap_onehot('0);
      gain_mode   <= 1'b0;
      pwr_down    <= 1'b0;
      analog_en   <= 1'b1;
      out_enable  <= 1'b1;
      gain_tenths <= '0;
    end else begin
      coarse_sel  <= tap_onehot(word.coarse);
      fine_sel    <= tap_onehot(word.fine);
      gain_mode   <= word.boost;
      pwr_down    <= word.pdn;
      analog_en   <= ~word.pdn;
      out_enable  <= ~word.pdn;
      gain_tenths <= gain_readout(word.coarse, word.fine, word.boost);
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(coarse_sel) == 1) && ($countones(fine_sel) == 1)); // R4
  AST_PDN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    word.pdn |=> (!analog_en && !out_enable));                  // R6
  AST_RUN_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !word.pdn |=> (analog_en && out_enable));                   // R6
endmodule

// File: rtl/gainctl_top.sv
module gainctl_top
  import gainctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [7:0]               bus_data,
  input  logic                     bus_addr,
  input  logic                     bus_cs_n,
  input  logic                     bus_wr_n,
  output logic [15:0]              coarse_sel,
  output logic [15:0]              fine_sel,
  output logic                     gain_mode,
  output logic                     pwr_down,
  output logic                     analog_en,
  output logic                     out_enable,
  output logic signed [9:0]        gain_tenths
);
  localparam int CTL_W = 3;

  logic [DATA_W-1:0] data_s;
  logic [CTL_W-1:0]  ctl_s;
  logic              lo_stb, hi_stb;
  ctl_word_t         word;

  sync_chain #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_dsync (
    .clk(clk), .rst_n(rst_n), .d(bus_data), .q(data_s));

  sync_chain #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_csync (
    .clk(clk), .rst_n(rst_n), .d({bus_wr_n, bus_cs_n, bus_addr}), .q(ctl_s));

  write_detect u_wdet (
    .clk(clk), .rst_n(rst_n),
    .wr_n_s(ctl_s[2]), .cs_n_s(ctl_s[1]), .addr_s(ctl_s[0]),
    .lo_stb(lo_stb), .hi_stb(hi_stb));

  ctl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .lo_stb(lo_stb), .hi_stb(hi_stb),
    .data_s(data_s), .word(word));

  out_stage u_out (
    .clk(clk), .rst_n(rst_n), .word(word),
    .coarse_sel(coarse_sel), .fine_sel(fine_sel), .gain_mode(gain_mode),
    .pwr_down(pwr_down), .analog_en(analog_en), .out_enable(out_enable),
    .gain_tenths(gain_tenths));
endmodule

// File: tb/sim_gainctl_top.sv
module sim_gainctl_top;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [7:0]        bus_data = 8'h00;
  logic              bus_addr = 1'b0;
  logic              bus_cs_n = 1'b1;
  logic              bus_wr_n = 1'b1;
  logic [15:0]       coarse_sel, fine_sel;
  logic              gain_mode, pwr_down, analog_en, out_enable;
  logic signed [9:0] gain_tenths;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  typedef struct {
    int    c, f, boost, pdn;
    string req;
  } exp_t;
  exp_t exp_q[$];
  int mc = 0, mf = 0, mb = 0, mp = 0;   // bench model of stored word

  always #4 clk = ~clk;

  gainctl_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .bus_addr(bus_addr),
    .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n), .coarse_sel(coarse_sel),
    .fine_sel(fine_sel), .gain_mode(gain_mode), .pwr_down(pwr_down),
    .analog_en(analog_en), .out_enable(out_enable), .gain_tenths(gain_tenths));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic chk_all(input exp_t e);
    int g;
    g = (15 * e.c + e.f) * (e.boost ? 1 : -1);
    chk(coarse_sel == (16'h1 << e.c), e.req, "coarse_sel", int'(coarse_sel), 1 << e.c);
    chk(fine_sel == (16'h1 << e.f), e.req, "fine_sel", int'(fine_sel), 1 << e.f);
    chk(int'(gain_mode) == e.boost, e.req, "gain_mode", int'(gain_mode), e.boost);
    chk(int'(pwr_down) == e.pdn, e.req, "pwr_down", int'(pwr_down), e.pdn);
    chk(int'(analog_en) == 1 - e.pdn, e.req, "analog_en", int'(analog_en), 1 - e.pdn);
    chk(int'(out_enable) == 1 - e.pdn, e.req, "out_enable", int'(out_enable), 1 - e.pdn);
    chk(int'(gain_tenths) == g, e.req, "gain_tenths", int'(gain_tenths), g);
  endtask

  function automatic exp_t snap(input string req);
    exp_t e;
    e.c = mc; e.f = mf; e.boost = mb; e.pdn = mp; e.req = req;
    return e;
  endfunction

  // driver: full bus cycle, then push the expected word
  task automatic bus_write(input bit a, input logic [7:0] d, input bit sel, input string req);
    @(negedge clk);
    bus_data = d; bus_addr = a; bus_cs_n = ~sel;
    repeat (3) @(negedge clk);
    bus_wr_n = 1'b0;
    repeat (3) @(negedge clk);
    bus_wr_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_cs_n = 1'b1;
    if (sel) begin
      if (!a) begin mc = int'(d[7:4]); mf = int'(d[3:0]); end
      else    begin mb = int'(d[0]);   mp = int'(d[1]);   end
    end
    exp_q.push_back(snap(req));
    wait (exp_q.size() == 0);
    @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      wait (exp_q.size() > 0);
      repeat (5) @(posedge clk);
      @(negedge clk);
      chk_all(exp_q[0]);
      void'(exp_q.pop_front());
    end
  end

  initial begin
    #(8 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!finished) begin
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    exp_t old_e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_all(snap("R8"));

    bus_write(1'b0, 8'h35, 1'b1, "R3 R4 R5");    // coarse 3 fine 5 attenuate: -50
    bus_write(1'b1, 8'h01, 1'b1, "R3 R5");       // gain mode: +50
    bus_write(1'b0, 8'hFF, 1'b1, "R4 R5");       // max: +240
    bus_write(1'b0, 8'h00, 1'b0, "R2");          // select high: ignored
    bus_write(1'b1, 8'h00, 1'b0, "R2");          // select high: ignored
    bus_write(1'b1, 8'h03, 1'b1, "R6");          // powerdown, gain
    bus_write(1'b0, 8'h21, 1'b1, "R7");          // write while powered down
    bus_write(1'b1, 8'h00, 1'b1, "R6 R7");       // wake, attenuate: -31

    // R1: strobe held low changes nothing; R9: latency after rise
    old_e = snap("R1");
    @(negedge clk);
    bus_data = 8'h90; bus_addr = 1'b0; bus_cs_n = 1'b0;
    repeat (3) @(negedge clk);
    bus_wr_n = 1'b0;
    repeat (10) @(negedge clk);
    chk_all(old_e);
    bus_wr_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    old_e.req = "R9";
    chk_all(old_e);
    @(posedge clk);
    @(negedge clk);
    mc = 9; mf = 0;
    chk_all(snap("R9"));
    bus_cs_n = 1'b1;
    repeat (4) @(negedge clk);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule